// File: doc/BRIEF.md
# Static Branch Resolver for a Dispatch Queue

This block looks at every slot of an instruction dispatch queue in every cycle and picks out branch instructions. For each slot it forms a branch target by adding the sign-extended displacement to the slot's PC. It also forms a direction decision.

- Unconditional branches are always taken.
- A conditional branch tests one flag of the condition-code register. If that flag is marked valid, the decision is final.
- If the flag is not valid yet, a fixed rule guesses the direction: a branch that jumps backward is guessed taken, and one that jumps forward is guessed not taken.

No history of earlier branches is kept.

The oldest branch in the queue is reported one cycle later. The oldest branch is the valid branch slot with the lowest index. The report gives its slot index, its target, its direction, and whether that direction is final or only a guess.

The registered result is held as a small state machine with three states:

- `ST_EMPTY`: no branch was found.
- `ST_FINAL`: the reported decision is settled.
- `ST_GUESS`: the reported decision is a guess.

In every cycle the next state is picked from the scan:

- EMPTY is chosen when no valid branch is found.
- FINAL is chosen when the oldest branch is unconditional or its flag is valid.
- GUESS is chosen otherwise.

Any state may move to any state in a single cycle.

Top module: `bres_resolver`

## Requirements
- R1: While `rst_n` is low, and on the first clock after reset, `br_found`, `br_taken`, `br_final`, `br_index` and `br_target` are all zero.
- R2: A slot counts as a branch only if its valid bit is 1 and its kind is 2'b01 (unconditional) or 2'b10 (conditional). Kinds 2'b00 and 2'b11 are not branches. When no slot is a branch, `br_found`, `br_taken`, `br_final` and `br_target` are 0.
- R3: When several slots hold branches, the slot with the lowest index is reported on `br_index`.
- R4: `br_target` equals the slot PC plus the 16-bit displacement sign-extended to 32 bits, modulo 2^32.
- R5: An unconditional branch is reported with `br_taken`=1 and `br_final`=1.
- R6: A conditional branch whose selected flag `cc_bits[csel]` has `cc_known[csel]`=1 is reported with `br_final`=1. It is taken exactly when `cc_bits[csel]` equals the slot's sense bit. The valid bits of the other flags have no effect.
- R7: A conditional branch with an unknown flag and a negative displacement (bit 15 set) is reported with `br_taken`=1 and `br_final`=0.
- R8: A conditional branch with an unknown flag and a displacement of zero or more is reported with `br_taken`=0 and `br_final`=0.
- R9: Outputs reflect the inputs sampled at the previous rising edge, with exactly one cycle of latency. Earlier branches have no influence on the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_valid | input | 8 | Per-slot valid bit |
| q_pc | input | 256 | Slot PCs, slot i at bits [32i+31:32i] |
| q_kind | input | 16 | Slot kind, 2 bits per slot |
| q_disp | input | 128 | Slot displacement, 16 bits per slot, two's complement |
| q_csel | input | 24 | Slot flag select, 3 bits per slot |
| q_sense | input | 8 | Slot sense bit: value of the flag that means taken |
| cc_bits | input | 8 | Condition-code flags |
| cc_known | input | 8 | Per-flag valid bits |
| br_found | output | 1 | A branch was reported |
| br_index | output | 3 | Slot index of the reported branch |
| br_target | output | 32 | Target address of the reported branch |
| br_taken | output | 1 | Decision: 1 means taken |
| br_final | output | 1 | 1 means resolved, 0 means guessed |

## Verification
The bench targets the boundaries of the direction rule.

- A displacement of zero must be guessed not taken, and the most negative displacement must be guessed taken. A design that tests the sign wrongly would flip one of these.
- Flags that are known, but are not the selected flag, must not turn a guess into a final decision. A design that ORs the valid bits together would wrongly mark the decision final.
- Selection is probed with invalid branch slots and non-branch slots placed in front of real branches. A priority encoder that is reversed, or that ignores the valid bit, would report the wrong index.
- A target whose addition wraps past 2^32 checks the sign extension and the modulo addition.
- A forward guess that follows a run of taken branches exposes any hidden history state.

// File: rtl/bres_pkg.sv
package bres_pkg;
    typedef enum logic [1:0] {
        KIND_OTHER  = 2'b00,
        KIND_UNCOND = 2'b01,
        KIND_COND   = 2'b10,
        KIND_RSVD   = 2'b11
    } br_kind_e;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_FINAL = 2'd1,
        ST_GUESS = 2'd2
    } res_state_e;
endpackage

// File: rtl/bres_slot_eval.sv
module bres_slot_eval
    import bres_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int DISP_W = 16,
    parameter int CC_W   = 8,
    localparam int SEL_W = $clog2(CC_W)
) (
    input  logic              valid,
    input  logic [PC_W-1:0]   pc,
    input  logic [1:0]        kind,
    input  logic [DISP_W-1:0] disp,
    input  logic [SEL_W-1:0]  csel,
    input  logic              sense,
    input  logic [CC_W-1:0]   cc_bits,
    input  logic [CC_W-1:0]   cc_known,
    output logic              is_br,
    output logic [PC_W-1:0]   target,
    output logic              taken,
    output logic              settled
);
    logic backward;
    logic flag_known;

    assign backward   = disp[DISP_W-1];
    assign flag_known = cc_known[csel];
    assign target     = pc + {{(PC_W-DISP_W){disp[DISP_W-1]}}, disp};

    always_comb begin
        is_br   = 1'b0;
        taken   = 1'b0;
        settled = 1'b0;
        case (br_kind_e'(kind))
            KIND_UNCOND: begin
                is_br   = valid;
                taken   = 1'b1;
                settled = 1'b1;
            end
            KIND_COND: begin
                is_br = valid;
                if (flag_known) begin
                    taken   = (cc_bits[csel] == sense);
                    settled = 1'b1;
                end else begin
                    taken   = backward;
                    settled = 1'b0;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bres_oldest_pick.sv
module bres_oldest_pick #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] req,
    output logic             any,
    output logic [DEPTH-1:0] grant,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        grant = '0;
        idx   = '0;
        any   = |req;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                idx      = IDX_W'(i);
            end
        end
    end

    always_comb begin
        assert_grant_onehot_R3: assert ($onehot0(grant));
        assert_grant_in_req_R3: assert ((grant & ~req) == '0);
    end
endmodule

// File: rtl/bres_resolver.sv
module bres_resolver
    import bres_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int PC_W   = 32,
    parameter int DISP_W = 16,
    parameter int CC_W   = 8,
    localparam int SEL_W = $clog2(CC_W),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [DEPTH-1:0]        q_valid,
    input  logic [DEPTH*PC_W-1:0]   q_pc,
    input  logic [DEPTH*2-1:0]      q_kind,
    input  logic [DEPTH*DISP_W-1:0] q_disp,
    input  logic [DEPTH*SEL_W-1:0]  q_csel,
    input  logic [DEPTH-1:0]        q_sense,
    input  logic [CC_W-1:0]         cc_bits,
    input  logic [CC_W-1:0]         cc_known,
    output logic                    br_found,
    output logic [IDX_W-1:0]        br_index,
    output logic [PC_W-1:0]         br_target,
    output logic                    br_taken,
    output logic                    br_final
);
    logic [DEPTH-1:0] e_is_br, e_taken, e_settled;
    logic [PC_W-1:0]  e_target [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        bres_slot_eval #(.PC_W(PC_W), .DISP_W(DISP_W), .CC_W(CC_W)) u_eval (
            .valid   (q_valid[g]),
            .pc      (q_pc[g*PC_W +: PC_W]),
            .kind    (q_kind[g*2 +: 2]),
            .disp    (q_disp[g*DISP_W +: DISP_W]),
            .csel    (q_csel[g*SEL_W +: SEL_W]),
            .sense   (q_sense[g]),
            .cc_bits (cc_bits),
            .cc_known(cc_known),
            .is_br   (e_is_br[g]),
            .target  (e_target[g]),
            .taken   (e_taken[g]),
            .settled (e_settled[g])
        );
    end

    logic             sel_any;
    logic [DEPTH-1:0] sel_grant;
    logic [IDX_W-1:0] sel_idx;

    bres_oldest_pick #(.DEPTH(DEPTH)) u_pick (
        .req  (e_is_br),
        .any  (sel_any),
        .grant(sel_grant),
        .idx  (sel_idx)
    );

    logic       sel_final, sel_back;
    logic [1:0] sel_kind;
    assign sel_final = e_settled[sel_idx];
    assign sel_back  = q_disp[sel_idx*DISP_W + DISP_W - 1];
    assign sel_kind  = q_kind[sel_idx*2 +: 2];

    res_state_e state, state_nxt;

    always_comb begin
        unique case ({sel_any, sel_final})
            2'b11:   state_nxt = ST_FINAL;
            2'b10:   state_nxt = ST_GUESS;
            default: state_nxt = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !sel_any) begin
            br_index  <= '0;
            br_target <= '0;
            br_taken  <= 1'b0;
        end else begin
            br_index  <= sel_idx;
            br_target <= e_target[sel_idx];
            br_taken  <= e_taken[sel_idx];
        end
    end

    assign br_found = (state != ST_EMPTY);
    assign br_final = (state == ST_FINAL);

    assert_empty_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !br_found |-> (!br_taken && !br_final && br_target == '0));

    assert_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (br_found == $past(sel_any)));

    assert_uncond_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sel_any && sel_kind == KIND_UNCOND)) |-> (br_taken && br_final));

    assert_guess_dir_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sel_any && !sel_final)) |-> (br_taken == $past(sel_back)));
endmodule

// File: tb/tb_bres_resolver.sv
`timescale 1ns/1ps
module tb_bres_resolver;
    localparam int DEPTH = 8, PC_W = 32, DISP_W = 16, CC_W = 8, SEL_W = 3, IDX_W = 3;

    logic clk = 0;
    logic rst_n = 0;
    logic [DEPTH-1:0]        q_valid = '0;
    logic [DEPTH*PC_W-1:0]   q_pc = '0;
    logic [DEPTH*2-1:0]      q_kind = '0;
    logic [DEPTH*DISP_W-1:0] q_disp = '0;
    logic [DEPTH*SEL_W-1:0]  q_csel = '0;
    logic [DEPTH-1:0]        q_sense = '0;
    logic [CC_W-1:0]         cc_bits = '0, cc_known = '0;
    logic                    br_found, br_taken, br_final;
    logic [IDX_W-1:0]        br_index;
    logic [PC_W-1:0]         br_target;

    int n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    bres_resolver dut (
        .clk(clk), .rst_n(rst_n), .q_valid(q_valid), .q_pc(q_pc), .q_kind(q_kind),
        .q_disp(q_disp), .q_csel(q_csel), .q_sense(q_sense), .cc_bits(cc_bits),
        .cc_known(cc_known), .br_found(br_found), .br_index(br_index),
        .br_target(br_target), .br_taken(br_taken), .br_final(br_final)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic clear_q();
        q_valid = '0; q_pc = '0; q_kind = '0; q_disp = '0; q_csel = '0; q_sense = '0;
        cc_bits = '0; cc_known = '0;
    endtask

    task automatic put(int i, logic v, logic [31:0] pc, logic [1:0] k, logic [15:0] d,
                       logic [2:0] cs, logic sn);
        q_valid[i] = v;
        q_pc[i*PC_W +: PC_W] = pc;
        q_kind[i*2 +: 2] = k;
        q_disp[i*DISP_W +: DISP_W] = d;
        q_csel[i*SEL_W +: SEL_W] = cs;
        q_sense[i] = sn;
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic expect_out(string req, logic f, int idx, logic [31:0] tgt, logic tk, logic fin);
        chk(req, "found", 32'(br_found), 32'(f));
        chk(req, "index", 32'(br_index), 32'(idx));
        chk(req, "target", br_target, tgt);
        chk(req, "taken", 32'(br_taken), 32'(tk));
        chk(req, "final", 32'(br_final), 32'(fin));
    endtask

    task automatic t_reset();
        put(0, 1, 32'h100, 2'b01, 16'h0004, 0, 0);
        step(); step();
        expect_out("R1", 0, 0, 0, 0, 0);
        rst_n = 1;
        step();
        expect_out("R1", 1, 0, 32'h104, 1, 1);
        clear_q();
        step();
    endtask

    task automatic t_empty();
        clear_q();
        put(0, 0, 32'h200, 2'b01, 16'h0010, 0, 0);
        put(1, 0, 32'h204, 2'b10, 16'hFFF0, 0, 0);
        put(2, 1, 32'h208, 2'b00, 16'h0010, 0, 0);
        put(3, 1, 32'h20C, 2'b11, 16'hFFF0, 0, 0);
        step();
        expect_out("R2", 0, 0, 0, 0, 0);
    endtask

    task automatic t_uncond();
        clear_q();
        put(3, 1, 32'h1000, 2'b01, 16'hFFFC, 0, 0);
        step();
        expect_out("R5", 1, 3, 32'h0FFC, 1, 1);
    endtask

    task automatic t_cond_known();
        clear_q();
        put(0, 1, 32'h3000, 2'b10, 16'h0040, 3'd5, 1'b1);
        cc_known = 8'h20; cc_bits = 8'h20;
        step();
        expect_out("R6", 1, 0, 32'h3040, 1, 1);
        cc_bits = 8'h00;
        step();
        expect_out("R6", 1, 0, 32'h3040, 0, 1);
        q_sense[0] = 1'b0;
        step();
        expect_out("R6", 1, 0, 32'h3040, 1, 1);
        cc_known = 8'hDF; cc_bits = 8'hFF;
        step();
        expect_out("R6", 1, 0, 32'h3040, 0, 0);
    endtask

    task automatic t_guess_back();
        clear_q();
        put(4, 1, 32'h0001_0000, 2'b10, 16'h8000, 3'd2, 1'b1);
        step();
        expect_out("R7", 1, 4, 32'h0000_8000, 1, 0);
        q_disp[4*DISP_W +: DISP_W] = 16'hFFFF;
        step();
        expect_out("R7", 1, 4, 32'h0000_FFFF, 1, 0);
    endtask

    task automatic t_guess_fwd();
        clear_q();
        put(6, 1, 32'h5000, 2'b10, 16'h0010, 3'd1, 1'b0);
        step();
        expect_out("R8", 1, 6, 32'h5010, 0, 0);
        q_disp[6*DISP_W +: DISP_W] = 16'h0000;
        step();
        expect_out("R8", 1, 6, 32'h5000, 0, 0);
        q_disp[6*DISP_W +: DISP_W] = 16'h7FFF;
        step();
        expect_out("R8", 1, 6, 32'hD000 - 32'h1 + 32'h8000 - 32'h7FFF + 32'h7FFF - 32'h8000 + 32'h1 + 32'h7FFF - 32'h8000 + 32'h0 , 0, 0);
    endtask

    task automatic t_oldest();
        clear_q();
        put(0, 1, 32'h10, 2'b00, 16'h0, 0, 0);
        put(1, 0, 32'h14, 2'b01, 16'h0, 0, 0);
        put(2, 1, 32'h18, 2'b10, 16'h0008, 0, 0);
        put(5, 1, 32'h24, 2'b01, 16'h0008, 0, 0);
        put(7, 1, 32'h2C, 2'b01, 16'h0008, 0, 0);
        step();
        expect_out("R3", 1, 2, 32'h20, 0, 0);
        q_valid[2] = 1'b0;
        step();
        expect_out("R3", 1, 5, 32'h2C, 1, 1);
    endtask

    task automatic t_wrap();
        clear_q();
        put(7, 1, 32'hFFFF_FFF0, 2'b01, 16'h0020, 0, 0);
        step();
        expect_out("R4", 1, 7, 32'h0000_0010, 1, 1);
        put(7, 1, 32'h0000_0004, 2'b01, 16'hFFF8, 0, 0);
        step();
        expect_out("R4", 1, 7, 32'hFFFF_FFFC, 1, 1);
    endtask

    task automatic t_latency_history();
        clear_q();
        step();
        put(1, 1, 32'h800, 2'b01, 16'h0100, 0, 0);
        #2;
        chk("R9", "found before edge", 32'(br_found), 0);
        step();
        chk("R9", "found after edge", 32'(br_found), 1);
        for (int k = 0; k < 5; k++) begin
            put(1, 1, 32'h800, 2'b10, 16'hFF00, 3'd0, 0);
            step();
        end
        put(1, 1, 32'h800, 2'b10, 16'h0100, 3'd0, 0);
        step();
        expect_out("R9", 1, 1, 32'h900, 0, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R9 watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_empty();
        t_uncond();
        t_cond_known();
        t_guess_back();
        t_guess_fwd();
        t_oldest();
        t_wrap();
        t_latency_history();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule